// File: doc/BRIEF.md
# Ten-Lane Signed Multiply-Accumulate Row

This block is a single row of ten processing lanes that work out ten dot products side by side, one for each output neuron of a small fully connected layer. On each accepted beat, one signed 8-bit activation goes to every lane. Each lane also takes its own signed 8-bit weight. A lane multiplies the two values and adds the product into a private 32-bit running sum. The caller marks the final beat of a pass. On that beat each lane adds its own 32-bit bias in place of a product.

The row has no column counter. The caller decides how many columns a pass has. A 64-column layer therefore uses 65 accepted beats: 64 products and one bias beat. A 100-column layer uses 101 beats. All ten sums come out together, with a one-cycle done pulse, and they stay on the outputs until the next pass starts.

The operand input uses a valid/ready handshake. `in_ready` is always high, so the row never applies back-pressure. A beat counts exactly when `in_valid` is high. The source may leave gaps of any length between beats.

Top module: `mac_row10`

## Requirements
- R1: Every lane k computes the signed product of the shared activation `act_i` and its own weight `wgt_i[8k+7:8k]`, with both treated as two's-complement 8-bit values. It adds that product into its own result `res_o[32k+31:32k]`.
- R2: `start` clears all ten sums in the cycle it is sampled. If `in_valid` is high in that same cycle, the sum becomes that beat's contribution alone. If `in_valid` is low, the sum becomes zero.
- R3: A cycle with `in_valid` low and `start` low leaves every result unchanged, whatever the values on `act_i`, `wgt_i`, `bias_i` and `in_last`.
- R4: Products are sign-extended from 16 to 32 bits before they are added. Sums wrap modulo 2^32 with no saturation.
- R5: On an accepted beat with `in_last` high, each lane adds its sign-extended 32-bit bias `bias_i[32k+31:32k]`. The activation and the weights on that beat are ignored.
- R6: `done_o` is high for exactly the one cycle after each accepted beat with `in_last` high, and it is low at every other time.
- R7: After a bias beat, the results hold their values until the next accepted beat or the next `start`.
- R8: `in_ready` is always high out of reset. Passes of any column count work, including 64 columns (65 beats) and 100 columns (101 beats).
- R9: While reset is asserted and right after it, all results are zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears all lane sums at the start of a pass |
| in_valid | input | 1 | Operand beat is present |
| in_ready | output | 1 | Row accepts a beat (always high) |
| in_last | input | 1 | Marks the bias beat that ends a pass |
| act_i | input | 8 | Shared signed activation |
| wgt_i | input | 80 | Ten signed weights, lane k at bits 8k+7:8k |
| bias_i | input | 320 | Ten signed biases, lane k at bits 32k+31:32k |
| done_o | output | 1 | One-cycle pulse after the bias beat |
| res_o | output | 320 | Ten 32-bit sums, lane k at bits 32k+31:32k |

## Verification
- **Single-column sweep.** Every one of the 256 activation values is paired with a different weight on each lane. This catches sign-extension or operand-swap faults in any lane. In the same passes the bias beat carries unrelated activation and weight values, which shows they are ignored.
- **64-column pass with gaps.** The bench drives changing operands while `in_valid` is low, which separates accepted beats from idle cycles.
- **100-column pass at -128 × -128.** All lanes see the largest possible product on every column, which tests the longer pass at its extreme values.
- **Bias boundaries.** Biases at both ends of the 32-bit signed range expose wrap and saturation mistakes.
- **Restart cases.** A `start` arrives both with and without an operand, partway through a pass. This separates clearing from accumulating.

// File: rtl/mac_row_pkg.sv
package mac_row_pkg;
  // Sign-extend a PROD_W-bit two's-complement value to ACC_W bits.
  function automatic logic [31:0] sext16to32(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // Reference signed 8x8 product, widened to 32 bits (used by the checker).
  function automatic logic [31:0] ref_prod(input logic [7:0] a, input logic [7:0] w);
    logic signed [15:0] ae;
    logic signed [15:0] we;
    logic signed [15:0] p;
    ae = {{8{a[7]}}, a};
    we = {{8{w[7]}}, w};
    p  = ae * we;
    return sext16to32(p);
  endfunction
endpackage

// File: rtl/mac_row_ctrl.sv
module mac_row_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic lane_clr,
  output logic lane_en,
  output logic lane_bias,
  output logic done_o
);
  logic done_q;

  // The row never stalls; every presented beat is taken.
  assign in_ready  = rst_n;
  assign lane_clr  = start;
  assign lane_en   = in_valid;
  assign lane_bias = in_valid & in_last;

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= in_valid & in_last;
  end

  assign done_o = done_q;
endmodule

// File: rtl/mac_row_pe.sv
module mac_row_pe #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             use_bias,
  input  logic [IN_W-1:0]  act,
  input  logic [IN_W-1:0]  wgt,
  input  logic [ACC_W-1:0] bias,
  output logic [ACC_W-1:0] acc_o
);
  localparam int PROD_W = 2 * IN_W;

  logic signed [PROD_W-1:0] act_x;
  logic signed [PROD_W-1:0] wgt_x;
  logic signed [PROD_W-1:0] prod;
  logic        [ACC_W-1:0]  prod_x;
  logic        [ACC_W-1:0]  addend;
  logic        [ACC_W-1:0]  base;
  logic        [ACC_W-1:0]  acc_q;

  always_comb begin
    act_x  = {{IN_W{act[IN_W-1]}}, act};
    wgt_x  = {{IN_W{wgt[IN_W-1]}}, wgt};
    prod   = act_x * wgt_x;
    prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    addend = use_bias ? bias : prod_x;
    base   = clr ? '0 : acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (en)  acc_q <= base + addend;
    else if (clr) acc_q <= '0;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mac_row10.sv
module mac_row10 #(
  parameter int LANES = 10,
  parameter int IN_W  = 8,
  parameter int ACC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_last,
  input  logic [IN_W-1:0]        act_i,
  input  logic [LANES*IN_W-1:0]  wgt_i,
  input  logic [LANES*ACC_W-1:0] bias_i,
  output logic                   done_o,
  output logic [LANES*ACC_W-1:0] res_o
);
  logic lane_clr;
  logic lane_en;
  logic lane_bias;

  mac_row_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .lane_clr  (lane_clr),
    .lane_en   (lane_en),
    .lane_bias (lane_bias),
    .done_o    (done_o)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mac_row_pe #(.IN_W(IN_W), .ACC_W(ACC_W)) u_pe (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (lane_clr),
      .en       (lane_en),
      .use_bias (lane_bias),
      .act      (act_i),
      .wgt      (wgt_i[k*IN_W +: IN_W]),
      .bias     (bias_i[k*ACC_W +: ACC_W]),
      .acc_o    (res_o[k*ACC_W +: ACC_W])
    );
  end
endmodule

// File: rtl/mac_row10_chk.sv
module mac_row10_chk #(
  parameter int LANES = 10,
  parameter int IN_W  = 8,
  parameter int ACC_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_last,
  input logic [IN_W-1:0]        act_i,
  input logic [LANES*IN_W-1:0]  wgt_i,
  input logic [LANES*ACC_W-1:0] bias_i,
  input logic                   done_o,
  input logic [LANES*ACC_W-1:0] res_o
);
  import mac_row_pkg::*;

  logic [31:0] lane0_prod;
  logic [31:0] lane9_prod;
  assign lane0_prod = ref_prod(act_i, wgt_i[7:0]);
  assign lane9_prod = ref_prod(act_i, wgt_i[LANES*IN_W-1 -: 8]);

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> $stable(res_o));  // R3
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_valid) |=> (res_o == '0));  // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> done_o);  // R6
  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !done_o);  // R6
  AST_LANE0_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last && !start) |=>
      (res_o[31:0] == $past(res_o[31:0]) + $past(lane0_prod)));  // R1
  AST_LANE9_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last && !start) |=>
      (res_o[LANES*ACC_W-1 -: 32] == $past(res_o[LANES*ACC_W-1 -: 32]) + $past(lane9_prod)));  // R4
  AST_LANE0_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !start) |=>
      (res_o[31:0] == $past(res_o[31:0]) + $past(bias_i[31:0])));  // R5
endmodule

bind mac_row10 mac_row10_chk #(.LANES(LANES), .IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .act_i    (act_i),
  .wgt_i    (wgt_i),
  .bias_i   (bias_i),
  .done_o   (done_o),
  .res_o    (res_o)
);

// File: tb/mac_row10_tb.sv
module mac_row10_tb;
  localparam int CLK_P = 10;
  localparam int LANES = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic in_ready;
  logic [7:0] act_i = '0;
  logic [LANES*8-1:0] wgt_i;
  logic [LANES*32-1:0] bias_i;
  logic done_o;
  logic [LANES*32-1:0] res_o;

  int w_cur [LANES];
  int b_cur [LANES];
  longint expv [LANES];
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      wgt_i[k*8 +: 8]   = 8'(w_cur[k]);
      bias_i[k*32 +: 32] = 32'(b_cur[k]);
    end
  end

  mac_row10 u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_last(in_last), .act_i(act_i), .wgt_i(wgt_i),
    .bias_i(bias_i), .done_o(done_o), .res_o(res_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
    end
  endtask

  task automatic check_res(input string req);
    for (int k = 0; k < LANES; k++)
      chk(res_o[k*32 +: 32] == 32'(expv[k]), req,
          longint'($signed(res_o[k*32 +: 32])), longint'($signed(32'(expv[k]))));
  endtask

  // Drive one cycle at a negedge; model it; return at the next negedge.
  task automatic beat(input bit st, input bit v, input bit l, input int a);
    start = st; in_valid = v; in_last = l; act_i = 8'(a);
    if (st) for (int k = 0; k < LANES; k++) expv[k] = 0;
    if (v) for (int k = 0; k < LANES; k++) begin
      if (l) expv[k] = expv[k] + longint'(b_cur[k]);
      else   expv[k] = expv[k] + longint'(a) * longint'(w_cur[k]);
    end
    @(negedge clk);
    start = 0; in_valid = 0; in_last = 0;
  endtask

  function automatic int to_s8(input int x);
    return int'($signed(8'(x)));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < LANES; k++) begin w_cur[k] = 0; b_cur[k] = 0; expv[k] = 0; end
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R9 done in reset", longint'(done_o), 0);
    check_res("R9 results in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready", longint'(in_ready), 1);
    check_res("R9 results after reset");

    // R1 R5 R6 R7: single-column sweep over every activation value
    for (int a = -128; a < 128; a++) begin
      for (int k = 0; k < LANES; k++) begin
        w_cur[k] = to_s8(a * 7 + k * 29);
        b_cur[k] = k * 1000 - 5000 + a;
      end
      beat(1, 1, 0, a);
      chk(done_o == 1'b0, "R6 no done mid pass", longint'(done_o), 0);
      for (int k = 0; k < LANES; k++) w_cur[k] = to_s8(a + 55 + k);
      beat(0, 1, 1, 127 - a);  // R5: act/weights ignored on bias beat
      chk(done_o == 1'b1, "R6 done pulse", longint'(done_o), 1);
      check_res("R1 R5 single column result");
      act_i = 8'(a + 3);
      @(negedge clk);
      chk(done_o == 1'b0, "R6 done one cycle", longint'(done_o), 0);
      check_res("R7 hold after done");
    end

    // R3 R8: 64 columns with idle gaps carrying garbage operands
    for (int c = 0; c < 64; c++) begin
      for (int k = 0; k < LANES; k++) w_cur[k] = to_s8(c * 13 - k * 41 + 7);
      beat(c == 0, 1, 0, to_s8(c * 31 + 5));
      if (c % 5 == 2) begin
        for (int k = 0; k < LANES; k++) begin w_cur[k] = 99; b_cur[k] = 12345; end
        beat(0, 0, 1, 77);
        check_res("R3 idle no change");
        chk(done_o == 1'b0, "R6 no done on idle last", longint'(done_o), 0);
      end
    end
    for (int k = 0; k < LANES; k++) b_cur[k] = -70000 + k * 9999;
    beat(0, 1, 1, 0);
    chk(done_o == 1'b1, "R8 done 64 column", longint'(done_o), 1);
    check_res("R8 64 column pass");

    // R8: 100 columns at the extreme product
    for (int k = 0; k < LANES; k++) begin w_cur[k] = -128; b_cur[k] = 0; end
    for (int c = 0; c < 100; c++) beat(c == 0, 1, 0, -128);
    beat(0, 1, 1, 0);
    chk(done_o == 1'b1, "R8 done 100 column", longint'(done_o), 1);
    check_res("R8 100 column pass");

    // R4: wrap at both ends of the signed range
    for (int k = 0; k < LANES; k++) begin
      w_cur[k] = (k % 2 == 0) ? 127 : -128;
      b_cur[k] = (k % 2 == 0) ? 32'h7FFFFFFF : 32'h80000000;
    end
    beat(1, 1, 0, 127);
    beat(0, 1, 1, 0);
    check_res("R4 wrap modulo 2^32");

    // R7: hold over many idle cycles
    repeat (20) begin
      act_i = 8'($urandom);
      @(negedge clk);
    end
    check_res("R7 long hold");

    // R2: start with operand mid pass; then start alone
    for (int k = 0; k < LANES; k++) w_cur[k] = 3 + k;
    beat(1, 1, 0, 10);
    beat(0, 1, 0, 20);
    beat(0, 1, 0, -30);
    beat(1, 1, 0, -5);
    check_res("R2 start with operand");
    beat(1, 0, 0, 50);
    check_res("R2 start alone clears");
    chk(done_o == 1'b0, "R6 no done after start", longint'(done_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule